// File: doc/BRIEF.md
# Serial Programming Frame Engine

This block is the device-side end of a one-wire programming link. Bits arrive already recovered, as a one-cycle `rx_valid` strobe with the bit value on `rx_bit`. The engine frames read and write commands, checks a 3-bit CRC on each one, and turns accepted commands into single-cycle requests on a simple synchronous memory port. The port has one select line that chooses between the non-volatile space and the volatile register space.

Access is closed after reset. A write of a fixed key word to a fixed address opens it. If that key does not arrive within a parameterised number of cycles, the block shuts access until the next reset. Each accepted read produces a 35-bit reply frame. The reply carries the stored value and the two error-correction status bits returned by the memory. It is shifted out one bit per `tx_en` pulse.

A receive timeout drops any partial frame if the bit stream stalls mid-frame. The receiver then goes back to looking for the start of a frame.

Top module: `serprog_engine`

## Requirements
- R1: A frame begins with two 0 bits. A 1 seen where a start bit is expected is dropped, and the receiver keeps looking for a start. Next comes one direction bit (1 = read, 0 = write), then a 6-bit address sent MSB first. A read then ends with a 3-bit CRC. A write carries 30 data bits, MSB first, before its 3-bit CRC.
- R2: The CRC uses the polynomial x^3+x+1 and starts from zero. It covers the direction bit, the address and (for writes) the data, in wire order, and is sent MSB first. A frame whose CRC does not match causes no memory request and no reply.
- R3: A write with a good CRC to address 0x24 with data 0x2781_1F77 opens access and sets `unlocked`. A frame carrying this key never produces a memory request.
- R4: While access is closed, every other good frame is dropped: no memory request and no reply.
- R5: If the key has not arrived when TIMEOUT_CYC cycles have passed since reset, `locked_out` rises. It stays high until reset, and every later frame is refused, including the key.
- R6: An accepted write pulses `mem_req` for one cycle, two clock edges after the edge that takes the last CRC bit. During that pulse, `mem_we`=1, `mem_space` = address bit 5 (1 = register space), `mem_addr` = address bits 4:0, and `mem_wdata` = data bits 23:0. Data bits 29:24 are ignored.
- R7: An accepted read pulses `mem_req` with `mem_we`=0 and the same address mapping. `mem_rdata` and `mem_ecc` are sampled in the cycle after the pulse.
- R8: The reply frame is 35 bits, sent MSB first: two 0 bits, four 0 bits, `mem_ecc[1:0]`, `mem_rdata[23:0]`, then the CRC of R2 over those 30 data bits. `tx_valid` stays high while reply bits remain, `tx_bit` shows the current bit, and each `tx_en` pulse advances one bit.
- R9: If more than GAP_MAX cycles pass without `rx_valid` in the middle of a frame, the partial frame is dropped and framing restarts.
- R10: After reset, `unlocked`, `locked_out`, `mem_req` and `tx_valid` are all 0. `unlocked` and `locked_out` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received bit strobe |
| rx_bit | input | 1 | Received bit value |
| tx_en | input | 1 | Advance reply by one bit |
| tx_valid | output | 1 | Reply bits remain |
| tx_bit | output | 1 | Current reply bit |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_space | output | 1 | 1 = register space, 0 = non-volatile space |
| mem_addr | output | 5 | Word address within the space |
| mem_wdata | output | 24 | Write payload |
| mem_rdata | input | 24 | Read data from memory |
| mem_ecc | input | 2 | Error-correction status from memory |
| unlocked | output | 1 | Access is open |
| locked_out | output | 1 | Key timeout expired, access refused |

## Verification
Counting from the clock edge that takes the last CRC bit, `mem_req` is due after two edges and the reply is loaded after four. `locked_out` is due at the TIMEOUT_CYC-th edge after reset is released. The bench drives bits on falling edges with one idle cycle between them. It records `mem_req` and its fields on rising edges, then waits a fixed margin of falling edges before comparing them. Reply bits are read on falling edges before each `tx_en` pulse. The timeout is checked just before and just after the edge on which it is due.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 30;
  localparam int PAY_W   = 24;
  localparam int ECC_W   = 2;
  localparam int CRC_W   = 3;
  localparam int START_W = 2;
  localparam int REPLY_W = START_W + DATA_W + CRC_W;
  localparam int IDX_W   = 6;

  // bit positions within a frame, counted from the first start bit
  localparam logic [IDX_W-1:0] P_DIR      = IDX_W'(START_W);
  localparam logic [IDX_W-1:0] P_ADDR_END = IDX_W'(START_W + ADDR_W);
  localparam logic [IDX_W-1:0] P_RD_LAST  = IDX_W'(START_W + 1 + ADDR_W + CRC_W - 1);
  localparam logic [IDX_W-1:0] P_DATA_END = IDX_W'(START_W + ADDR_W + DATA_W);
  localparam logic [IDX_W-1:0] P_WR_LAST  = IDX_W'(START_W + 1 + ADDR_W + DATA_W + CRC_W - 1);

  localparam logic [ADDR_W-1:0] KEY_ADDR = 6'h24;
  localparam logic [DATA_W-1:0] KEY_DATA = 30'h2781_1F77;

  // one serial step of the x^3+x+1 CRC register
  function automatic logic [CRC_W-1:0] crc3_next(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[2];
    return {c[1], c[0] ^ fb, fb};
  endfunction

  function automatic logic [CRC_W-1:0] crc3_word(input logic [DATA_W-1:0] w);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = DATA_W - 1; i >= 0; i--) c = crc3_next(c, w[i]);
    return c;
  endfunction

  function automatic logic [REPLY_W-1:0] build_reply(input logic [ECC_W-1:0] ecc,
                                                     input logic [PAY_W-1:0] val);
    logic [DATA_W-1:0] w;
    w = {{(DATA_W - ECC_W - PAY_W){1'b0}}, ecc, val};
    return {{START_W{1'b0}}, w, crc3_word(w)};
  endfunction

endpackage

// File: rtl/serprog_rx.sv
module serprog_rx
  import serprog_pkg::*;
#(
  parameter int GAP_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_bit,
  output logic              frm_done,
  output logic              frm_ok,
  output logic              frm_rd,
  output logic [ADDR_W-1:0] frm_addr,
  output logic [DATA_W-1:0] frm_data
);
  localparam int GW = $clog2(GAP_MAX + 1);
  localparam logic [GW-1:0] GAP_LIM = GW'(GAP_MAX);

  logic [IDX_W-1:0] idx;
  logic [GW-1:0]    gap_cnt;
  logic [CRC_W-1:0] crc_run, crc_rx;
  logic             in_frame, frame_last, rx_abort;

  assign in_frame   = (idx != '0);
  assign frame_last = frm_rd ? (idx == P_RD_LAST) : (idx == P_WR_LAST);
  assign rx_abort   = !rx_valid && in_frame && (gap_cnt == GAP_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      gap_cnt  <= '0;
      crc_run  <= '0;
      crc_rx   <= '0;
      frm_done <= 1'b0;
      frm_ok   <= 1'b0;
      frm_rd   <= 1'b0;
      frm_addr <= '0;
      frm_data <= '0;
    end else begin
      frm_done <= 1'b0;
      if (rx_valid) begin
        gap_cnt <= '0;
        if (idx < P_DIR) begin
          idx <= rx_bit ? '0 : idx + IDX_W'(1);
        end else if (idx == P_DIR) begin
          frm_rd  <= rx_bit;
          crc_run <= crc3_next('0, rx_bit);
          idx     <= idx + IDX_W'(1);
        end else if (idx <= P_ADDR_END) begin
          frm_addr <= {frm_addr[ADDR_W-2:0], rx_bit};
          crc_run  <= crc3_next(crc_run, rx_bit);
          idx      <= idx + IDX_W'(1);
        end else if (!frm_rd && idx <= P_DATA_END) begin
          frm_data <= {frm_data[DATA_W-2:0], rx_bit};
          crc_run  <= crc3_next(crc_run, rx_bit);
          idx      <= idx + IDX_W'(1);
        end else begin
          crc_rx <= {crc_rx[CRC_W-2:0], rx_bit};
          if (frame_last) begin
            idx      <= '0;
            frm_done <= 1'b1;
            frm_ok   <= ({crc_rx[CRC_W-2:0], rx_bit} == crc_run);
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
      end else if (rx_abort) begin
        idx     <= '0;
        gap_cnt <= '0;
      end else if (in_frame) begin
        gap_cnt <= gap_cnt + GW'(1);
      end
    end
  end

  AST_ABORT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |=> !in_frame && !frm_done); // R9

endmodule

// File: rtl/serprog_gate.sv
module serprog_gate
  import serprog_pkg::*;
#(
  parameter int TIMEOUT_CYC = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_done,
  input  logic              frm_ok,
  input  logic              frm_rd,
  input  logic [ADDR_W-1:0] frm_addr,
  input  logic [DATA_W-1:0] frm_data,
  output logic              key_hit,
  output logic              accept,
  output logic              open_q,
  output logic              dead_q
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] wait_cnt;
  logic          good_frame;

  assign good_frame = frm_done && frm_ok;
  assign key_hit    = good_frame && !frm_rd && (frm_addr == KEY_ADDR) && (frm_data == KEY_DATA);
  assign accept     = good_frame && open_q && !key_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      dead_q   <= 1'b0;
      wait_cnt <= '0;
    end else if (!open_q && !dead_q) begin
      if (key_hit)                open_q   <= 1'b1;
      else if (wait_cnt == T_LAST) dead_q  <= 1'b1;
      else                        wait_cnt <= wait_cnt + TW'(1);
    end
  end

  AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dead_q |=> dead_q && !open_q); // R5
  AST_OPEN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_q && dead_q)); // R10

endmodule

// File: rtl/serprog_tx.sv
module serprog_tx
  import serprog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ECC_W-1:0] ecc,
  input  logic [PAY_W-1:0] val,
  input  logic             tx_en,
  output logic             tx_valid,
  output logic             tx_bit
);
  localparam int CW = $clog2(REPLY_W + 1);

  logic [REPLY_W-1:0] sh;
  logic [CW-1:0]      left;

  assign tx_valid = (left != '0);
  assign tx_bit   = sh[REPLY_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (load) begin
      sh   <= build_reply(ecc, val);
      left <= CW'(REPLY_W);
    end else if (tx_en && tx_valid) begin
      sh   <= {sh[REPLY_W-2:0], 1'b0};
      left <= left - CW'(1);
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_en && !load |=> $stable(tx_bit) && tx_valid); // R8

endmodule

// File: rtl/serprog_engine.sv
module serprog_engine
  import serprog_pkg::*;
#(
  parameter int TIMEOUT_CYC = 20000,
  parameter int GAP_MAX     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_bit,
  input  logic        tx_en,
  output logic        tx_valid,
  output logic        tx_bit,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_space,
  output logic [4:0]  mem_addr,
  output logic [23:0] mem_wdata,
  input  logic [23:0] mem_rdata,
  input  logic [1:0]  mem_ecc,
  output logic        unlocked,
  output logic        locked_out
);
  logic              frm_done, frm_ok, frm_rd;
  logic [ADDR_W-1:0] frm_addr;
  logic [DATA_W-1:0] frm_data;
  logic              key_hit, accept, rd_pend;

  serprog_rx #(.GAP_MAX(GAP_MAX)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .frm_done(frm_done), .frm_ok(frm_ok), .frm_rd(frm_rd),
    .frm_addr(frm_addr), .frm_data(frm_data)
  );

  serprog_gate #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_ok(frm_ok),
    .frm_rd(frm_rd), .frm_addr(frm_addr), .frm_data(frm_data),
    .key_hit(key_hit), .accept(accept), .open_q(unlocked), .dead_q(locked_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_space <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_pend   <= 1'b0;
    end else begin
      mem_req <= accept;
      rd_pend <= mem_req && !mem_we;
      if (accept) begin
        mem_we    <= !frm_rd;
        mem_space <= frm_addr[ADDR_W-1];
        mem_addr  <= frm_addr[ADDR_W-2:0];
        mem_wdata <= frm_rd ? '0 : frm_data[PAY_W-1:0];
      end
    end
  end

  serprog_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(rd_pend), .ecc(mem_ecc), .val(mem_rdata),
    .tx_en(tx_en), .tx_valid(tx_valid), .tx_bit(tx_bit)
  );

  AST_REQ_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> unlocked && !locked_out); // R4
  AST_BADCRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && !frm_ok |=> !mem_req); // R2
  AST_KEY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> !mem_req); // R3
  AST_REPLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(mem_req, 2) && !$past(mem_we, 2)); // R7

endmodule

// File: tb/test_serprog_engine.sv
module test_serprog_engine;
  localparam int TMO = 4000;
  localparam int GAP = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_bit = 1'b0, tx_en = 1'b0;
  logic tx_valid, tx_bit, mem_req, mem_we, mem_space, unlocked, locked_out;
  logic [4:0] mem_addr;
  logic [23:0] mem_wdata, mem_rdata = '0;
  logic [1:0] mem_ecc = '0;

  int checks = 0, errors = 0, req_cnt = 0;
  bit done = 0;
  logic cap_we, cap_space;
  logic [4:0] cap_addr;
  logic [23:0] cap_wdata;

  always #10 clk = ~clk;

  serprog_engine #(.TIMEOUT_CYC(TMO), .GAP_MAX(GAP)) i_serprog_engine (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_en(tx_en),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .mem_req(mem_req), .mem_we(mem_we),
    .mem_space(mem_space), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ecc(mem_ecc), .unlocked(unlocked), .locked_out(locked_out)
  );

  always @(posedge clk) begin
    if (rst_n && mem_req) begin
      req_cnt++;
      cap_we = mem_we; cap_space = mem_space; cap_addr = mem_addr; cap_wdata = mem_wdata;
    end
  end

  // remainder of message * x^3 divided by x^3+x+1, by long division
  function automatic logic [2:0] tb_crc(input logic [63:0] v, input int n);
    logic [3:0] r = '0;
    for (int i = n - 1; i >= -3; i--) begin
      r = {r[2:0], (i >= 0) ? v[i] : 1'b0};
      if (r[3]) r = r ^ 4'b1011;
    end
    return r[2:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_valid = 1'b1; rx_bit = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [63:0] v, input int n, input bit bad);
    logic [2:0] c;
    c = tb_crc(v, n) ^ (bad ? 3'b010 : 3'b000);
    send_bit(1'b0); send_bit(1'b0);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    for (int i = 2; i >= 0; i--) send_bit(c[i]);
    repeat (4) @(negedge clk);
  endtask

  task automatic send_write(input logic [5:0] a, input logic [29:0] d, input bit bad);
    send_frame({27'b0, 1'b0, a, d}, 37, bad);
  endtask

  task automatic send_read(input logic [5:0] a, input bit bad);
    send_frame({57'b0, 1'b1, a}, 7, bad);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic read_reply(input logic [1:0] ecc, input logic [23:0] val, input string tag);
    logic [34:0] got, exp;
    logic [63:0] w;
    int tries = 0;
    w = {34'b0, 4'b0, ecc, val};
    exp = {2'b00, w[29:0], tb_crc(w, 30)};
    while (!tx_valid && tries < 12) begin @(negedge clk); tries++; end
    got = '0;
    for (int i = 34; i >= 0; i--) begin
      got[i] = tx_bit;
      tx_en = 1'b1;
      @(negedge clk);
      tx_en = 1'b0;
    end
    chk(got == exp, tag, 64'(got), 64'(exp));
    chk(!tx_valid, "R8 tx_valid low after 35 bits", 64'(tx_valid), 0);
  endtask

  initial begin
    int base;
    logic [5:0] a;
    logic [29:0] d;
    logic [23:0] v;
    logic [1:0] e;
    void'($urandom(32'h5eed_0a17));
    do_reset;
    @(negedge clk);
    chk(!unlocked && !locked_out && !mem_req && !tx_valid, "R10 reset state",
        {unlocked, locked_out, mem_req, tx_valid}, 0);

    // R4: good frames while locked are dropped
    base = req_cnt;
    send_read(6'h05, 0);
    send_write(6'h21, 30'h0123456, 0);
    repeat (6) @(negedge clk);
    chk(req_cnt == base && !tx_valid, "R4 locked frames dropped", 64'(req_cnt - base), 0);

    // R2: key with bad CRC does not open
    send_write(6'h24, 30'h2781_1F77, 1);
    chk(!unlocked, "R2 bad CRC key ignored", 64'(unlocked), 0);

    // R9: partial key, long stall, then a full key
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    repeat (GAP + 8) @(negedge clk);
    send_write(6'h24, 30'h2781_1F77, 0);
    chk(unlocked, "R9 stall drops partial frame", 64'(unlocked), 1);
    // R3
    chk(req_cnt == base, "R3 key makes no memory request", 64'(req_cnt - base), 0);

    // R6: random writes with random ignored upper bits
    for (int k = 0; k < 12; k++) begin
      a = 6'($urandom); d = 30'($urandom);
      if (a == 6'h24) a = 6'h23;
      base = req_cnt;
      send_write(a, d, 0);
      chk(req_cnt == base + 1 && cap_we && cap_space == a[5] && cap_addr == a[4:0] &&
          cap_wdata == d[23:0], "R6 write request",
          {req_cnt - base, cap_we, cap_space, cap_addr, cap_wdata},
          {32'd1, 1'b1, a[5], a[4:0], d[23:0]});
    end
    // R6: upper bits all ones ignored
    send_write(6'h3f, 30'h3F00_0001, 0);
    chk(cap_wdata == 24'h000001, "R6 bits 29:24 ignored", 64'(cap_wdata), 1);

    // R7/R8: random reads
    for (int k = 0; k < 10; k++) begin
      a = 6'($urandom); v = 24'($urandom); e = 2'($urandom);
      mem_rdata = v; mem_ecc = e;
      base = req_cnt;
      send_read(a, 0);
      chk(req_cnt == base + 1 && !cap_we && cap_space == a[5] && cap_addr == a[4:0],
          "R7 read request", {req_cnt - base, cap_we, cap_space, cap_addr},
          {32'd1, 1'b0, a[5], a[4:0]});
      read_reply(e, v, "R8 reply frame");
    end
    // R8 corner: all-ones data and status
    mem_rdata = 24'hFFFFFF; mem_ecc = 2'b11;
    send_read(6'h00, 0);
    read_reply(2'b11, 24'hFFFFFF, "R8 reply all ones");

    // R1: stray 1 before start bits is dropped
    mem_rdata = 24'h00A5C3; mem_ecc = 2'b01;
    base = req_cnt;
    send_bit(1'b1);
    send_read(6'h2a, 0);
    chk(req_cnt == base + 1 && cap_addr == 5'h0a && cap_space, "R1 resync after stray 1",
        {req_cnt - base, cap_space, cap_addr}, {32'd1, 1'b1, 5'h0a});
    read_reply(2'b01, 24'h00A5C3, "R1 reply after resync");

    // R2: bad CRC while open
    base = req_cnt;
    send_write(6'h11, 30'h00BEEF, 1);
    send_read(6'h11, 1);
    repeat (6) @(negedge clk);
    chk(req_cnt == base && !tx_valid, "R2 bad CRC no access", 64'(req_cnt - base), 0);

    // R5: key timeout
    do_reset;
    repeat (TMO - 2) @(negedge clk);
    chk(!locked_out, "R5 not yet timed out", 64'(locked_out), 0);
    repeat (3) @(negedge clk);
    chk(locked_out && !unlocked, "R5 timed out", {locked_out, unlocked}, 2'b10);
    base = req_cnt;
    send_write(6'h24, 30'h2781_1F77, 0);
    send_read(6'h01, 0);
    repeat (6) @(negedge clk);
    chk(!unlocked && locked_out && req_cnt == base && !tx_valid, "R5 refuses after timeout",
        {unlocked, locked_out, req_cnt - base}, {1'b0, 1'b1, 32'd0});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule